// File: doc/BRIEF.md
# Issue-Stage Latency Interlock

This block sits at the issue stage of a single-issue, in-order pipeline with an integer path and a four-stage floating-point add path. In each cycle it looks at the decoded class and register fields of the instruction waiting to issue. It compares them with a small table of results still in flight. If issuing now would let a consumer read a value before it is ready, the block holds the instruction and lets a bubble go forward.

The required distance depends on two things together: the kind of producer and the way the consumer uses the value. An FP add feeding another FP add, an FP add feeding store data and a double load feeding an FP add each need a different number of intervening cycles. Each register has a countdown that is reloaded when a new producer issues and that drops by one on every cycle, stalls included. A stall therefore ends in exactly the cycle where the distance is met.

The instruction input is a valid/ready stream. When `in_ready` is low with `in_valid` high, the upstream stage must hold every field stable. The instruction issues on a clock edge where both are high. `out_valid` marks an issue, and a low `out_valid` is a bubble. There is no back-pressure from downstream.

Top module: `ilk_interlock`

## Requirements
- R1: A consumer that uses an FP register as an FP add source (class code 4, fields a and b) and that register's last producer was an FP add (code 4) needs 3 intervening cycles, so it stalls for 3 - d cycles when presented d cycles after the producer.
- R2: A store-double (code 3) whose data register (field b, FP file) was last written by an FP add needs 2 intervening cycles.
- R3: An FP add source last written by a load-double (code 2) needs 1 intervening cycle.
- R4: A load-double result used as store data, and an integer ALU result (code 1) used by an integer reader, need 0 cycles by default; the integer distance is the parameter `LAT_INT_INT`.
- R5: The stall lasts exactly max(0, L - d) cycles, where L is the required distance and d is the number of cycles between producer issue and consumer presentation. Countdowns keep falling during a stall, and no stall run exceeds the largest distance.
- R6: A store checks its base register (field a, integer file) under integer rules and its data register under store-data rules, and it stalls for the larger of the two shortfalls, not their sum. Load-double and branch bases (field a) follow integer rules.
- R7: Integer register 0 never creates a dependence, whatever was last written to it.
- R8: A branch (code 5) writes no register. The instruction in its delay slot is never held because of the branch, and the branch counts as one ordinary intervening cycle.
- R9: A synchronous reset marks every register of both files as ready.
- R10: `out_valid` is high exactly when an instruction issues. Idle cycles, idle-class instructions (code 0) and held instructions record no producer.
- R11: A newer producer to the same register replaces the older entry, so the countdown and the producer kind both restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present for issue |
| in_ready | output | 1 | Low while the instruction must be held |
| in_op | input | 3 | Class: 0 idle, 1 int ALU, 2 load-double, 3 store-double, 4 FP add, 5 branch |
| in_dst | input | REG_IDX_W | Destination register (int ALU: int file; load, FP add: FP file) |
| in_srca | input | REG_IDX_W | Source a (FP add: FP file; otherwise int file) |
| in_srcb | input | REG_IDX_W | Source b (int ALU: int file; FP add, store data: FP file) |
| out_valid | output | 1 | Instruction issued this cycle; low is a bubble |

## Verification
On every cycle the assertions check several properties. The countdown of each entry falls by one unless it is reloaded, and a reload sets it to the full window. Reset leaves every entry at zero. A back-to-back dependent FP add is held, an integer reader of register 0 is never held, and no stall run outlasts the largest window. The exact number of stall cycles for each producer and consumer pairing at distances 0 to 4 can only be shown by the bench's scenarios. The same is true of the max rule for stores, the branch delay slot, the replacement of a register's producer and reset in the middle of a run.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_INT  = 3'd1,
    OP_LDD  = 3'd2,
    OP_STD  = 3'd3,
    OP_FPA  = 3'd4,
    OP_BR   = 3'd5
  } op_class_e;

  // How a source field reads its register.
  typedef enum logic [1:0] {
    USE_NONE   = 2'd0,
    USE_INT    = 2'd1,
    USE_FP     = 2'd2,
    USE_STDATA = 2'd3
  } src_use_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ilk_decode.sv
module ilk_decode
  import ilk_pkg::*;
(
  input  logic [2:0] op,
  output src_use_e   use_a,
  output src_use_e   use_b,
  output logic       wr_int,
  output logic       wr_fp
);

  always_comb begin
    use_a  = USE_NONE;
    use_b  = USE_NONE;
    wr_int = 1'b0;
    wr_fp  = 1'b0;
    case (op)
      3'(OP_INT): begin
        use_a  = USE_INT;
        use_b  = USE_INT;
        wr_int = 1'b1;
      end
      3'(OP_LDD): begin
        use_a = USE_INT;
        wr_fp = 1'b1;
      end
      3'(OP_STD): begin
        use_a = USE_INT;
        use_b = USE_STDATA;
      end
      3'(OP_FPA): begin
        use_a = USE_FP;
        use_b = USE_FP;
        wr_fp = 1'b1;
      end
      3'(OP_BR): begin
        use_a = USE_INT;
      end
      default: begin
        use_a = USE_NONE;
      end
    endcase
  end

endmodule

// File: rtl/ilk_table.sv
module ilk_table
  import ilk_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int CW        = 2,
  parameter int MAX_LAT   = 3,
  parameter bit ZERO_LOCK = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  op_class_e        wr_cls,
  input  logic [IDX_W-1:0] rd_idx_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [CW-1:0]    rd_rem_a,
  output logic [CW-1:0]    rd_rem_b,
  output op_class_e        rd_cls_a,
  output op_class_e        rd_cls_b
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [CW-1:0] rem_q [ENTRIES];
  op_class_e     cls_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    if (ZERO_LOCK && i == 0) begin : g_lock
      assign rem_q[i] = '0;
      assign cls_q[i] = OP_IDLE;
    end else begin : g_live
      logic [CW-1:0] rem;
      op_class_e     cls;
      logic          hit;

      assign hit = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
        if (rst) begin
          rem <= '0;
          cls <= OP_IDLE;
        end else if (hit) begin
          rem <= CW'(MAX_LAT);
          cls <= wr_cls;
        end else if (rem != '0) begin
          rem <= rem - 1'b1;
        end
      end

      assign rem_q[i] = rem;
      assign cls_q[i] = cls;

      assert_countdown_R5: assert property (@(posedge clk) disable iff (rst)
        (!hit && rem != '0) |=> (rem == $past(rem) - 1'b1));

      assert_reload_R11: assert property (@(posedge clk) disable iff (rst)
        hit |=> (rem == CW'(MAX_LAT)));

      assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rem == '0));
    end
  end

  assign rd_rem_a = rem_q[rd_idx_a];
  assign rd_rem_b = rem_q[rd_idx_b];
  assign rd_cls_a = cls_q[rd_idx_a];
  assign rd_cls_b = cls_q[rd_idx_b];

endmodule

// File: rtl/ilk_need.sv
module ilk_need
  import ilk_pkg::*;
#(
  parameter int CW          = 2,
  parameter int MAX_LAT     = 3,
  parameter int LAT_FP_FP   = 3,
  parameter int LAT_FP_ST   = 2,
  parameter int LAT_LD_FP   = 1,
  parameter int LAT_LD_ST   = 0,
  parameter int LAT_INT_INT = 0
) (
  input  src_use_e      use_k,
  input  op_class_e     prod,
  input  logic [CW-1:0] rem,
  output logic          busy
);

  int lat;

  always_comb begin
    lat = 0;
    case (use_k)
      USE_INT: begin
        if (prod == OP_INT) lat = LAT_INT_INT;
      end
      USE_FP: begin
        if (prod == OP_FPA)      lat = LAT_FP_FP;
        else if (prod == OP_LDD) lat = LAT_LD_FP;
      end
      USE_STDATA: begin
        if (prod == OP_FPA)      lat = LAT_FP_ST;
        else if (prod == OP_LDD) lat = LAT_LD_ST;
      end
      default: lat = 0;
    endcase
    // Intervening cycles so far = MAX_LAT - rem; short if below lat.
    busy = (use_k != USE_NONE) && ((int'(rem) + lat) > MAX_LAT);
  end

endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
  import ilk_pkg::*;
#(
  parameter int REG_IDX_W   = 5,
  parameter int LAT_FP_FP   = 3,
  parameter int LAT_FP_ST   = 2,
  parameter int LAT_LD_FP   = 1,
  parameter int LAT_LD_ST   = 0,
  parameter int LAT_INT_INT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2:0]           in_op,
  input  logic [REG_IDX_W-1:0] in_dst,
  input  logic [REG_IDX_W-1:0] in_srca,
  input  logic [REG_IDX_W-1:0] in_srcb,
  output logic                 out_valid
);

  localparam int MAX_LAT = max2(max2(max2(LAT_FP_FP, LAT_FP_ST),
                                     max2(LAT_LD_FP, LAT_LD_ST)),
                                max2(LAT_INT_INT, 1));
  localparam int CW = $clog2(MAX_LAT + 1);
  localparam int NSRC = 2;

  src_use_e  use_a, use_b;
  logic      wr_int, wr_fp;
  logic      fire, stall;

  logic [CW-1:0] fp_rem_a, fp_rem_b, in_rem_a, in_rem_b;
  op_class_e     fp_cls_a, fp_cls_b, in_cls_a, in_cls_b;

  src_use_e      s_use [NSRC];
  logic [CW-1:0] s_rem [NSRC];
  op_class_e     s_cls [NSRC];
  logic [NSRC-1:0] s_busy;

  ilk_decode u_dec (
    .op     (in_op),
    .use_a  (use_a),
    .use_b  (use_b),
    .wr_int (wr_int),
    .wr_fp  (wr_fp)
  );

  ilk_table #(.IDX_W(REG_IDX_W), .CW(CW), .MAX_LAT(MAX_LAT), .ZERO_LOCK(1'b0)) u_fp_tab (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (fire && wr_fp),
    .wr_idx   (in_dst),
    .wr_cls   (op_class_e'(in_op)),
    .rd_idx_a (in_srca),
    .rd_idx_b (in_srcb),
    .rd_rem_a (fp_rem_a),
    .rd_rem_b (fp_rem_b),
    .rd_cls_a (fp_cls_a),
    .rd_cls_b (fp_cls_b)
  );

  ilk_table #(.IDX_W(REG_IDX_W), .CW(CW), .MAX_LAT(MAX_LAT), .ZERO_LOCK(1'b1)) u_int_tab (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (fire && wr_int),
    .wr_idx   (in_dst),
    .wr_cls   (op_class_e'(in_op)),
    .rd_idx_a (in_srca),
    .rd_idx_b (in_srcb),
    .rd_rem_a (in_rem_a),
    .rd_rem_b (in_rem_b),
    .rd_cls_a (in_cls_a),
    .rd_cls_b (in_cls_b)
  );

  // Source a reads the FP file only for FP adds; source b for FP reads and store data.
  assign s_use[0] = use_a;
  assign s_rem[0] = (use_a == USE_FP) ? fp_rem_a : in_rem_a;
  assign s_cls[0] = (use_a == USE_FP) ? fp_cls_a : in_cls_a;
  assign s_use[1] = use_b;
  assign s_rem[1] = (use_b == USE_INT) ? in_rem_b : fp_rem_b;
  assign s_cls[1] = (use_b == USE_INT) ? in_cls_b : fp_cls_b;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    ilk_need #(
      .CW(CW), .MAX_LAT(MAX_LAT),
      .LAT_FP_FP(LAT_FP_FP), .LAT_FP_ST(LAT_FP_ST),
      .LAT_LD_FP(LAT_LD_FP), .LAT_LD_ST(LAT_LD_ST),
      .LAT_INT_INT(LAT_INT_INT)
    ) u_need (
      .use_k (s_use[s]),
      .prod  (s_cls[s]),
      .rem   (s_rem[s]),
      .busy  (s_busy[s])
    );
  end

  assign stall     = in_valid && (s_busy != '0);
  assign in_ready  = !stall;
  assign fire      = in_valid && !stall && !rst;
  assign out_valid = fire;

  // Consecutive stall cycles, kept for the bound check only.
  logic [CW:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)                  run_q <= '0;
    else if (!stall)          run_q <= '0;
    else if (run_q < (CW+1)'(MAX_LAT)) run_q <= run_q + 1'b1;
  end

  assert_stall_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    stall |-> (run_q < (CW+1)'(MAX_LAT)));

  assert_zero_reg_free_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'(OP_INT) && in_srca == '0 && in_srcb == '0) |-> in_ready);

  if (LAT_FP_FP > 0) begin : g_fpfp_chk
    assert_fp_chain_held_R1: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(out_valid) && $past(in_op) == 3'(OP_FPA) &&
       in_valid && in_op == 3'(OP_FPA) && in_srca == $past(in_dst)) |-> !in_ready);
  end

endmodule

// File: tb/ilk_interlock_tb.sv
module ilk_interlock_tb;

  localparam logic [2:0] C_IDLE = 3'd0, C_INT = 3'd1, C_LDD = 3'd2,
                         C_STD = 3'd3, C_FPA = 3'd4, C_BR = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic v = 1'b0;
  logic [2:0] op = C_IDLE;
  logic [4:0] dst = '0, sa = '0, sb = '0;

  logic rdy_a, rdy_b, ov_a, ov_b, rdy, ov;

  always #5 clk = ~clk;

  ilk_interlock u_dut (
    .clk(clk), .rst(rst), .in_valid(v && !sel), .in_ready(rdy_a),
    .in_op(op), .in_dst(dst), .in_srca(sa), .in_srcb(sb), .out_valid(ov_a)
  );

  ilk_interlock #(.LAT_INT_INT(1)) u_dut_i (
    .clk(clk), .rst(rst), .in_valid(v && sel), .in_ready(rdy_b),
    .in_op(op), .in_dst(dst), .in_srca(sa), .in_srcb(sb), .out_valid(ov_b)
  );

  assign rdy = sel ? rdy_b : rdy_a;
  assign ov  = sel ? ov_b  : ov_a;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  string req_q[$];
  int stall_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: assumed to start at a falling edge.
  task automatic put(input logic [2:0] o, input logic [4:0] d, input logic [4:0] a,
                     input logic [4:0] b, input int exp_stall, input string req);
    exp_q.push_back(exp_stall);
    req_q.push_back(req);
    v = 1'b1; op = o; dst = d; sa = a; sb = b;
    forever begin
      #3;
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    v = 1'b0; op = C_IDLE;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: counts held cycles and compares at each issue.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (v) begin
        if (!rdy) begin
          stall_cnt++;
          chk(ov == 1'b0, "R10 bubble while held", int'(ov), 0);
        end else if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected issue", 1, 0);
        end else begin
          int e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(stall_cnt == e, r, stall_cnt, e);
          chk(ov == 1'b1 || rst, "R10 issue strobe", int'(ov), 1);
          stall_cnt = 0;
        end
      end
    end
  end

  function automatic int lref(input int p, input int c);
    if (p == 0 && c == 0) return 3;
    if (p == 0 && c == 1) return 2;
    if (p == 1 && c == 0) return 1;
    return 0;
  endfunction

  function automatic string tag(input int p, input int c);
    if (p == 0 && c == 0) return "R1 fp->fp";
    if (p == 0 && c == 1) return "R2 fp->store data";
    if (p == 1 && c == 0) return "R3 load->fp";
    if (p == 1)           return "R4 load->store data";
    if (c == 2)           return "R4 int->int";
    if (c == 5)           return "R8 int->branch";
    return "R6 int->base";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #3;
    chk(rdy == 1'b1 && ov == 1'b0, "R9 reset ready", int'(rdy), 1);
    @(negedge clk);
    put(C_FPA, 5'd12, 5'd7, 5'd8, 0, "R9 all ready after reset");
    idle(4);

    // Pair sweep at distances 0..4 on the default unit.
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 6; c++) begin
        for (int d = 0; d < 5; d++) begin
          int e;
          if ((p < 2) != (c < 2)) continue;
          e = lref(p, c) - d;
          if (e < 0) e = 0;
          case (p)
            0: put(C_FPA, 5'd7, 5'd9, 5'd10, 0, "R5 producer");
            1: put(C_LDD, 5'd7, 5'd9, 5'd0, 0, "R5 producer");
            default: put(C_INT, 5'd7, 5'd9, 5'd10, 0, "R5 producer");
          endcase
          for (int k = 0; k < d; k++) put(C_IDLE, 5'd0, 5'd0, 5'd0, 0, "R5 filler");
          case (c)
            0: put(C_FPA, 5'd20, 5'd7, 5'd9, e, tag(p, c));
            1: put(C_STD, 5'd0, 5'd9, 5'd7, e, tag(p, c));
            2: put(C_INT, 5'd21, 5'd7, 5'd9, e, tag(p, c));
            3: put(C_STD, 5'd0, 5'd7, 5'd9, e, tag(p, c));
            4: put(C_LDD, 5'd22, 5'd7, 5'd0, e, tag(p, c));
            default: put(C_BR, 5'd0, 5'd7, 5'd0, e, tag(p, c));
          endcase
          idle(4);
        end
      end
    end

    // R8: branch leaves its slot alone and counts as one slot.
    put(C_BR, 5'd0, 5'd9, 5'd0, 0, "R8 branch");
    put(C_INT, 5'd23, 5'd9, 5'd10, 0, "R8 delay slot");
    idle(4);
    put(C_FPA, 5'd7, 5'd9, 5'd10, 0, "R8 producer");
    put(C_BR, 5'd0, 5'd9, 5'd0, 0, "R8 branch");
    put(C_FPA, 5'd20, 5'd7, 5'd9, 2, "R8 slot dependent");
    idle(4);

    // R11: newer producer replaces older one.
    put(C_FPA, 5'd7, 5'd9, 5'd10, 0, "R11 old producer");
    put(C_IDLE, 5'd0, 5'd0, 5'd0, 0, "R11 filler");
    put(C_IDLE, 5'd0, 5'd0, 5'd0, 0, "R11 filler");
    put(C_LDD, 5'd7, 5'd9, 5'd0, 0, "R11 new producer");
    put(C_FPA, 5'd20, 5'd7, 5'd9, 1, "R11 replaced entry");
    idle(4);

    // R10: an invalid instruction records nothing.
    v = 1'b0; op = C_FPA; dst = 5'd7; sa = 5'd9; sb = 5'd10;
    repeat (2) @(negedge clk);
    put(C_FPA, 5'd20, 5'd7, 5'd9, 0, "R10 idle records nothing");
    idle(4);

    // R9: reset in mid-run clears pending producers.
    put(C_FPA, 5'd7, 5'd9, 5'd10, 0, "R9 producer");
    v = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    put(C_FPA, 5'd20, 5'd7, 5'd9, 0, "R9 cleared by reset");
    idle(4);

    // Unit with integer distance 1: R7 and R6.
    sel = 1'b1;
    put(C_INT, 5'd0, 5'd9, 5'd10, 0, "R7 write r0");
    put(C_INT, 5'd24, 5'd0, 5'd0, 0, "R7 r0 free");
    idle(4);
    put(C_INT, 5'd5, 5'd9, 5'd10, 0, "R4 int producer");
    put(C_INT, 5'd24, 5'd5, 5'd9, 1, "R4 int distance param");
    idle(4);
    put(C_INT, 5'd3, 5'd9, 5'd10, 0, "R6 base producer");
    put(C_FPA, 5'd4, 5'd9, 5'd10, 0, "R6 data producer");
    put(C_STD, 5'd0, 5'd3, 5'd4, 2, "R6 data dominates");
    idle(4);
    put(C_FPA, 5'd4, 5'd9, 5'd10, 0, "R6 data producer");
    put(C_INT, 5'd3, 5'd9, 5'd10, 0, "R6 base producer");
    put(C_STD, 5'd0, 5'd3, 5'd4, 1, "R6 max not sum");
    idle(4);

    chk(exp_q.size() == 0, "R10 all issued", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule